// File: doc/BRIEF.md
# Field-Rate Doubling Vertical Sync Sequencer

This block sits between an incoming video timing source and a display scan stage. It watches the incoming vertical sync and horizontal blanking. For each incoming field it records whether the vertical sync rising edge landed early or late in the blanking line, and calls that field phase A or phase B. From that measurement and a programmed raster code it issues display vertical sync pulses. With rate conversion enabled it issues two pulses per input field. With conversion disabled it issues one. A phase B pulse is placed half an output line later than a phase A pulse, so the output keeps the interlace relation of the source.

The block also drives a frame-switch signal. Depending on two configuration bits, that signal is held low, held high, or toggled on each display vertical sync. In the toggle modes it is overridden while an upstream, noise-cleaned vertical sync is high.

The sequencer is a four-state machine:
- `ST_IDLE`: waiting for a field to start.
- `ST_HOLD`: counting the half-line delay of a phase B field.
- `ST_PULSE`: display sync asserted.
- `ST_GAP`: waiting for the midpoint of the input field, where the second output field starts.

The transitions are:
- *launch*: any state to `ST_HOLD`, `ST_PULSE`, `ST_GAP` or `ST_IDLE` on an input field start, or from `ST_GAP` at the field midpoint.
- *delay done*: `ST_HOLD` to `ST_PULSE`.
- *pulse done*: `ST_PULSE` to `ST_GAP` or `ST_IDLE`.

Top module: `vsync_rate_doubler`

## Requirements
- R1: After reset, with all configuration bits zero, `vs2_out` and `mux_out` are low until the first input field starts.
- R2: An input field starts at the clock edge where `vs_in` is sampled high after being sampled low. The field is phase A when fewer than LINE_CLKS/2 edges separate it from the latest `bln_in` rising edge, counting a coincident edge as 0. Otherwise, and when no `bln_in` rise has been seen since reset, it is phase B.
- R3: A phase A output field raises `vs2_out` right after the edge at which that output field starts. A phase B field raises it LINE_CLKS/4 edges later with conversion, or LINE_CLKS/2 edges later without. The pulse lasts LINE_CLKS/2 cycles with conversion and LINE_CLKS cycles without.
- R4: With `conv_en` high, two output fields follow each input field start: one at the start edge and one FIELD_CLKS/2 edges later. With `conv_en` low, only the first one follows.
- R5: Raster code 00 (`cfg_in[1:0]`) gives every output field the measured phase. This yields AABB with conversion and AB without it.
- R6: Raster code 01 makes every output field phase A.
- R7: Raster code 10 with conversion makes the first output field phase B and the second phase A. Without conversion it produces no `vs2_out` pulse.
- R8: Raster code 11 produces no `vs2_out` pulse.
- R9: With `cfg_in[2]` (strobe) low, `mux_out` equals `cfg_in[3]` (invert). This gives 00 = held low and 10 = held high.
- R10: With strobe high, `mux_out` equals invert while `vs1_in` is high. Otherwise it equals a toggle bit that flips one cycle after each `vs2_out` rise and is cleared by reset.
- R11: The raster code and `conv_en` are captured at each input field start. Changing them later in a field does not alter that field's output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vs_in | input | 1 | Input vertical sync |
| bln_in | input | 1 | Input horizontal blanking; rising edge marks line start |
| vs1_in | input | 1 | Noise-cleaned vertical sync from an upstream stage |
| conv_en | input | 1 | High enables double field rate output |
| cfg_in | input | 4 | [1:0] raster code, [2] strobe, [3] invert |
| vs2_out | output | 1 | Display vertical sync |
| mux_out | output | 1 | Frame-switch signal |

## Verification
A field start is taken at the edge that first samples `vs_in` high. `vs2_out` rises right after that edge for phase A, or after a further LINE_CLKS/4 or LINE_CLKS/2 edges for phase B. The second converted field follows FIELD_CLKS/2 edges after the start. The toggle behind `mux_out` changes one cycle after each `vs2_out` rise, and `mux_out` otherwise follows `vs1_in` and the configuration bits in the same cycle.

The bench runs an edge-counting model that applies these delays. It compares both outputs at every falling clock edge, where the registers have settled for the edge just taken. It also logs the rise offset of every output pulse from its field start. It then checks the log, eight output fields at a time, against the expected A/B sequence.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } vrd_state_e;

    // fire: the output field carries a sync pulse; late: phase B placement
    typedef struct packed {
        logic fire;
        logic late;
    } field_pick_t;

    // Selects the phase of one output field from the raster code,
    // the conversion mode, the measured input phase and the field index.
    function automatic field_pick_t pick_field(
        input logic [1:0] raster,
        input logic       conv,
        input logic       meas_b,
        input logic       second
    );
        field_pick_t p;
        p.fire = 1'b1;
        p.late = meas_b;
        case (raster)
            2'b00: p.late = meas_b;
            2'b01: p.late = 1'b0;
            2'b10: begin
                p.fire = conv;
                p.late = ~second;
            end
            default: begin
                p.fire = 1'b0;
                p.late = 1'b0;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vrd_phase_detect.sv
module vrd_phase_detect #(
    parameter int LINE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_i,
    input  logic bln_i,
    output logic start_o,
    output logic late_o
);
    localparam int HALF = LINE_CLKS / 2;
    localparam int PW   = $clog2(HALF + 1);
    localparam logic [PW-1:0] HALF_V = PW'(HALF);

    logic          vs_q;
    logic          bln_q;
    logic          bln_rise;
    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_d;

    always_comb begin
        bln_rise = bln_i & ~bln_q;
        if (bln_rise)
            pos_d = '0;
        else if (pos_q == HALF_V)
            pos_d = HALF_V;
        else
            pos_d = pos_q + 1'b1;
        start_o = vs_i & ~vs_q;
        late_o  = (pos_d >= HALF_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q  <= 1'b0;
            bln_q <= 1'b0;
            pos_q <= HALF_V;
        end else begin
            vs_q  <= vs_i;
            bln_q <= bln_i;
            pos_q <= pos_d;
        end
    end

    // A field that starts on a blanking rise is always early (phase A)
    assert_coincident_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && bln_i && !bln_q) |-> !late_o);

endmodule

// File: rtl/vrd_field_fsm.sv
module vrd_field_fsm
    import vrd_pkg::*;
#(
    parameter int LINE_CLKS  = 64,
    parameter int FIELD_CLKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_start_i,
    input  logic       phase_b_i,
    input  logic [1:0] raster_i,
    input  logic       conv_i,
    output logic       vs2_o
);
    localparam int HF   = FIELD_CLKS / 2;
    localparam int CW   = $clog2(LINE_CLKS + 1);
    localparam int TW   = $clog2(HF + 1);
    localparam logic [CW-1:0] OFF_CONV_M1 = CW'(LINE_CLKS / 4 - 1);
    localparam logic [CW-1:0] OFF_NC_M1   = CW'(LINE_CLKS / 2 - 1);
    localparam logic [CW-1:0] WID_CONV_M1 = CW'(LINE_CLKS / 2 - 1);
    localparam logic [CW-1:0] WID_NC_M1   = CW'(LINE_CLKS - 1);
    localparam logic [TW-1:0] HF_M1       = TW'(HF - 1);

    vrd_state_e    state, state_n;
    logic [CW-1:0] cnt;
    logic [TW-1:0] ft;
    logic [1:0]    raster_l;
    logic          conv_l;
    logic          meas_b_l;
    logic          late_l;
    logic          second, second_n;
    logic          launch;
    logic          conv_now;
    field_pick_t   sel;
    field_pick_t   sel_first;
    field_pick_t   sel_second;
    logic [CW-1:0] off_m1;
    logic [CW-1:0] wid_m1;

    always_comb begin
        conv_now   = field_start_i ? conv_i : conv_l;
        sel_first  = pick_field(raster_i, conv_i, phase_b_i, 1'b0);
        sel_second = pick_field(raster_l, conv_l, meas_b_l, 1'b1);
        off_m1     = conv_l ? OFF_CONV_M1 : OFF_NC_M1;
        wid_m1     = conv_l ? WID_CONV_M1 : WID_NC_M1;
    end

    // next-state process
    always_comb begin
        state_n  = state;
        second_n = second;
        launch   = 1'b0;
        sel      = sel_first;
        unique case (state)
            ST_IDLE: ;
            ST_HOLD: begin
                if (cnt == off_m1)
                    state_n = ST_PULSE;
            end
            ST_PULSE: begin
                if (cnt == wid_m1)
                    state_n = (conv_l && !second) ? ST_GAP : ST_IDLE;
            end
            ST_GAP: begin
                if (ft == HF_M1) begin
                    launch   = 1'b1;
                    sel      = sel_second;
                    second_n = 1'b1;
                end
            end
        endcase
        if (field_start_i) begin
            launch   = 1'b1;
            sel      = sel_first;
            second_n = 1'b0;
        end
        if (launch) begin
            if (!sel.fire)
                state_n = (conv_now && !second_n) ? ST_GAP : ST_IDLE;
            else
                state_n = sel.late ? ST_HOLD : ST_PULSE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            second   <= 1'b0;
            cnt      <= '0;
            ft       <= '0;
            raster_l <= 2'b00;
            conv_l   <= 1'b0;
            meas_b_l <= 1'b0;
            late_l   <= 1'b0;
        end else begin
            state  <= state_n;
            second <= second_n;
            if (launch || state_n != state)
                cnt <= '0;
            else if (state == ST_HOLD || state == ST_PULSE)
                cnt <= cnt + 1'b1;
            if (field_start_i)
                ft <= '0;
            else if (ft != HF_M1)
                ft <= ft + 1'b1;
            if (field_start_i) begin
                raster_l <= raster_i;
                conv_l   <= conv_i;
                meas_b_l <= phase_b_i;
            end
            if (launch)
                late_l <= sel.late;
        end
    end

    // output process
    always_comb begin
        vs2_o = (state == ST_PULSE);
    end

    assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_l == 2'b11) |-> !vs2_o);

    assert_single_rate_b_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_l && raster_l == 2'b10) |-> !vs2_o);

    assert_pulse_not_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs2_o) |-> ($past(vs2_o, 2) || $past(field_start_i)));

    assert_gap_needs_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> conv_l);

    assert_late_goes_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> late_l);

endmodule

// File: rtl/vrd_mux_gen.sv
module vrd_mux_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic vs2_i,
    input  logic vs1_i,
    input  logic invert_i,
    input  logic strobe_i,
    output logic mux_o
);
    logic vs2_d;
    logic tog;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs2_d <= 1'b0;
            tog   <= 1'b0;
        end else begin
            vs2_d <= vs2_i;
            if (vs2_i && !vs2_d)
                tog <= ~tog;
        end
    end

    always_comb begin
        if (!strobe_i)
            mux_o = invert_i;
        else if (vs1_i)
            mux_o = invert_i;
        else
            mux_o = tog;
    end

    assert_toggle_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vs2_i && !vs2_d) |=> !$stable(tog));

    assert_toggle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs2_i && !vs2_d) |=> $stable(tog));

endmodule

// File: rtl/vsync_rate_doubler.sv
module vsync_rate_doubler #(
    parameter int LINE_CLKS  = 64,
    parameter int FIELD_CLKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vs_in,
    input  logic       bln_in,
    input  logic       vs1_in,
    input  logic       conv_en,
    input  logic [3:0] cfg_in,
    output logic       vs2_out,
    output logic       mux_out
);
    logic field_start;
    logic phase_b;

    vrd_phase_detect #(.LINE_CLKS(LINE_CLKS)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_i    (vs_in),
        .bln_i   (bln_in),
        .start_o (field_start),
        .late_o  (phase_b)
    );

    vrd_field_fsm #(.LINE_CLKS(LINE_CLKS), .FIELD_CLKS(FIELD_CLKS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .field_start_i (field_start),
        .phase_b_i     (phase_b),
        .raster_i      (cfg_in[1:0]),
        .conv_i        (conv_en),
        .vs2_o         (vs2_out)
    );

    vrd_mux_gen u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .vs2_i    (vs2_out),
        .vs1_i    (vs1_in),
        .invert_i (cfg_in[3]),
        .strobe_i (cfg_in[2]),
        .mux_o    (mux_out)
    );

endmodule

// File: tb/vsync_rate_doubler_tb.sv
module vsync_rate_doubler_tb;
    localparam int CLK_NS = 10;
    localparam int LINE   = 64;
    localparam int FIELD  = 2048;
    localparam int HF     = FIELD / 2;
    localparam int HALF   = LINE / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vs = 1'b0;
    logic       bln = 1'b0;
    logic       vs1 = 1'b0;
    logic       conv = 1'b1;
    logic [3:0] cfg = 4'b0000;
    logic       vs2_out;
    logic       mux_out;

    int checks = 0;
    int fails  = 0;
    int lc     = 0;

    always #(CLK_NS / 2) clk = ~clk;

    vsync_rate_doubler #(.LINE_CLKS(LINE), .FIELD_CLKS(FIELD)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_in   (vs),
        .bln_in  (bln),
        .vs1_in  (vs1),
        .conv_en (conv),
        .cfg_in  (cfg),
        .vs2_out (vs2_out),
        .mux_out (mux_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference rules written from the requirements
    function automatic bit ref_fire(input bit [1:0] r, input bit c);
        if (r == 2'b11) return 1'b0;
        if (r == 2'b10) return c;
        return 1'b1;
    endfunction

    function automatic bit ref_late(input bit [1:0] r, input bit pb, input int f);
        if (r == 2'b01) return 1'b0;
        if (r == 2'b10) return (f == 0);
        return pb;
    endfunction

    function automatic int ref_off(input bit late, input bit c);
        if (!late) return 0;
        return c ? LINE / 4 : LINE / 2;
    endfunction

    // behavioural model state
    int       m_cyc, m_pos, m_start;
    bit       m_have, m_phb, m_conv, m_vsp, m_blnp;
    bit [1:0] m_ras;
    bit       e_vs2, e_vs2_d, e_tog;
    int       obs[$];
    bit       obs_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_pos = HALF; m_have = 0; m_vsp = 0; m_blnp = 0;
            e_vs2 = 0; e_vs2_d = 0; e_tog = 0; m_start = 0;
        end else begin
            m_cyc++;
            if (e_vs2 && !e_vs2_d) e_tog = !e_tog;
            e_vs2_d = e_vs2;
            if (bln && !m_blnp) m_pos = 0;
            else if (m_pos < HALF) m_pos = m_pos + 1;
            if (vs && !m_vsp) begin
                m_have = 1; m_start = m_cyc; m_phb = (m_pos >= HALF);
                m_conv = conv; m_ras = cfg[1:0];
            end
            m_vsp = vs; m_blnp = bln;
            e_vs2 = 0;
            if (m_have) begin
                for (int f = 0; f < 2; f++) begin
                    if (f == 1 && !m_conv) continue;
                    if (ref_fire(m_ras, m_conv)) begin
                        int s, o, w;
                        s = m_start + f * HF;
                        o = ref_off(ref_late(m_ras, m_phb, f), m_conv);
                        w = m_conv ? LINE / 2 : LINE;
                        if (m_cyc >= s + o && m_cyc < s + o + w) e_vs2 = 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit em;
            em = cfg[2] ? (vs1 ? cfg[3] : e_tog) : cfg[3];
            chk(vs2_out == e_vs2, (m_ras == 2'b11) ? "R8" : "R3", "vs2 per cycle", vs2_out, e_vs2);
            chk(mux_out == em, cfg[2] ? "R10" : "R9", "mux per cycle", mux_out, em);
            if (vs2_out && !obs_prev) obs.push_back(m_cyc - m_start);
            obs_prev = vs2_out;
        end else begin
            obs_prev = 1'b0;
        end
    end

    // blanking: rises at line position 0, high for three quarters of the line
    initial begin
        forever begin
            @(negedge clk);
            #1;
            lc  = (lc + 1) % LINE;
            bln = (lc < (LINE * 3) / 4);
        end
    end

    task automatic run_field(input bit phb, input int chg_at, input logic [3:0] chg_cfg);
        int tgt;
        tgt = phb ? 40 : 10;
        do begin
            @(negedge clk); #2;
        end while (lc != tgt);
        vs = 1'b1; vs1 = 1'b1;
        for (int i = 0; i < FIELD - LINE; i++) begin
            @(negedge clk); #2;
            if (i == 128) begin vs = 1'b0; vs1 = 1'b0; end
            if (i == chg_at) cfg = chg_cfg;
        end
    endtask

    task automatic run_seq(input string req, input bit c, input logic [3:0] cf,
                           input bit [7:0] phases, input int n);
        int exp[$];
        conv = c; cfg = cf;
        for (int i = 0; i < n; i++) begin
            for (int f = 0; f < (c ? 2 : 1); f++) begin
                if (ref_fire(cf[1:0], c))
                    exp.push_back(f * HF + ref_off(ref_late(cf[1:0], phases[i], f), c));
            end
        end
        obs.delete();
        for (int i = 0; i < n; i++) run_field(phases[i], -1, cf);
        chk(obs.size() == exp.size(), req, "output field count", obs.size(), exp.size());
        for (int k = 0; k < exp.size() && k < obs.size(); k++)
            chk(obs[k] == exp[k], {req, " R2 R3"}, "pulse rise offset", obs[k], exp[k]);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        obs_prev = 1'b0;
        for (int i = 0; i < 190000; i++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(vs2_out == 1'b0, "R1", "vs2 after reset", vs2_out, 0);
        chk(mux_out == 1'b0, "R1", "mux after reset", mux_out, 0);

        // AABB, mux held low: phases A B B A
        run_seq("R5 R4", 1'b1, 4'b0000, 8'b0000_0110, 4);
        // AAAA, mux toggling, low while vs1 high
        run_seq("R6 R10", 1'b1, 4'b0101, 8'b0000_1010, 4);
        // BABA, mux toggling, high while vs1 high
        run_seq("R7 R10", 1'b1, 4'b1110, 8'b0000_0011, 4);
        // undefined code, mux held high
        run_seq("R8 R9", 1'b1, 4'b1011, 8'b0000_0101, 4);
        // single rate AB over 8 fields
        run_seq("R5 R4", 1'b0, 4'b0000, 8'b1010_0110, 8);
        run_seq("R6", 1'b0, 4'b0001, 8'b0000_1101, 4);
        run_seq("R7", 1'b0, 4'b0010, 8'b0000_0011, 2);

        // R11: raster changes to 01 mid-field; the running field keeps code 00
        begin
            conv = 1'b1; cfg = 4'b0000;
            obs.delete();
            run_field(1'b1, 300, 4'b0001);
            run_field(1'b1, -1, 4'b0001);
            chk(obs.size() == 4, "R11", "field count", obs.size(), 4);
            if (obs.size() == 4) begin
                chk(obs[0] == LINE / 4, "R11", "first field late", obs[0], LINE / 4);
                chk(obs[1] == HF + LINE / 4, "R11", "second field late", obs[1], HF + LINE / 4);
                chk(obs[2] == 0, "R11", "new code early", obs[2], 0);
                chk(obs[3] == HF, "R11", "new code second", obs[3], HF);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule